// File: doc/BRIEF.md
# Serial Audio Input Deserializer

This block takes a two-channel serial audio stream made of a data line, a bit clock and a word clock that marks left and right. It rebuilds parallel 16-bit two's-complement samples. All three inputs are sampled by a faster system clock through synchronizers, and edges are found in that clock domain. Every rising bit-clock edge shifts one data bit, MSB first, into a serial-to-parallel register. Every word-clock transition copies the latest sample width of bits into the first-stage register of the channel that the transition completes. Any bits sent earlier in a longer slot drop out of the shift register and are lost.

A second register stage per channel sits between the input side and the consumer. It loads only when the consumer pulses its own frame-start strobe, and a valid pulse goes with each load. Between strobes, the outputs keep the previous sample pair while new words arrive in the first stage. Jitter on the word clock therefore never reaches the output timing. The system clock must run at least four times faster than the bit clock.

Top module: `serial_audio_deser`

## Requirements
- R1: While reset is asserted and directly after it, `left_o` and `right_o` are zero and `valid_o` is low.
- R2: Data is taken on rising bit-clock edges only. The last bit shifted before a word edge becomes bit 0 and the earliest retained bit becomes bit 15, so the sample is MSB first and is passed on unchanged as a two's-complement word.
- R3: When a channel slot carries more than 16 bits, only the 16 bits shifted immediately before the word-clock transition are captured. The earlier bits are discarded.
- R4: With the default polarity (`LEFT_ON_FALL` = 1), a falling word-clock edge completes the left sample and a rising edge completes the right sample.
- R5: `valid_o` is high for exactly the cycle after a clock edge at which `frame_start_i` was high, and is low otherwise.
- R6: After reset, no valid pulse is issued and the outputs stay zero until one left capture followed by one right capture has completed.
- R7: `left_o` and `right_o` change only at a clock edge where `frame_start_i` is high. Words captured since the last strobe do not show on the outputs until the next strobe.
- R8: On a strobe edge, `left_o` and `right_o` take the most recently captured left and right words, and these are visible in the same cycle as the valid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial inputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| sdata_i | input | 1 | Serial audio data, MSB first |
| bclk_i | input | 1 | Bit clock; data is taken on its rising edge |
| wclk_i | input | 1 | Word clock; its transitions end channel slots |
| frame_start_i | input | 1 | Consumer strobe that loads the output stage |
| left_o | output | 16 | Left sample, two's complement |
| right_o | output | 16 | Right sample, two's complement |
| valid_o | output | 1 | One-cycle pulse marking a new output pair |

## Verification
A bit-clock or word-clock transition acts three system-clock edges after it reaches the pins: two synchronizer flops, then the edge register and the action itself. The bench therefore holds data for four cycles on each side of every bit-clock edge and waits several cycles after each word-clock toggle before it pulses the strobe. It drives the strobe for one cycle starting at a falling edge. It samples outputs and `valid_o` at the next falling edge, which is half a cycle after the loading edge, and again one cycle later to confirm the pulse has ended. Unchanged outputs are checked just before each strobe, after fresh words have been captured.

// File: rtl/sad_pkg.sv
package sad_pkg;
   localparam int SAD_SAMPLE_W = 16;
   localparam int SAD_SYNC_MIN = 2;

   typedef enum logic [0:0] {
      CH_LEFT  = 1'b0,
      CH_RIGHT = 1'b1
   } sad_chan_e;

   typedef struct packed {
      logic sdata;
      logic bclk;
      logic wclk;
   } sad_lines_t;
endpackage

// File: rtl/sad_sync.sv
module sad_sync #(
   parameter int W      = 3,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] async_i,
   output logic [W-1:0] sync_o,
   output logic [W-1:0] prev_o
);
   initial begin
      if (STAGES < sad_pkg::SAD_SYNC_MIN) $error("sad_sync: STAGES below minimum");
      if (W < 1) $error("sad_sync: W must be positive");
   end

   logic [W-1:0] pipe [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe[0] <= '0;
      else        pipe[0] <= async_i;
   end

   for (genvar g = 1; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pipe[g] <= '0;
         else        pipe[g] <= pipe[g-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_o <= '0;
      else        prev_o <= pipe[STAGES-1];
   end

   assign sync_o = pipe[STAGES-1];
endmodule

// File: rtl/sad_sipo.sv
module sad_sipo #(
   parameter int SAMPLE_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                shift_i,
   input  logic                bit_i,
   output logic [SAMPLE_W-1:0] word_o
);
   initial begin
      if (SAMPLE_W < 2) $error("sad_sipo: SAMPLE_W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       word_o <= '0;
      else if (shift_i) word_o <= {word_o[SAMPLE_W-2:0], bit_i};
   end
endmodule

// File: rtl/sad_chan_regs.sv
module sad_chan_regs #(
   parameter int SAMPLE_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cap_left_i,
   input  logic                cap_right_i,
   input  logic [SAMPLE_W-1:0] word_i,
   input  logic                frame_start_i,
   output logic [SAMPLE_W-1:0] s1_left_o,
   output logic [SAMPLE_W-1:0] s1_right_o,
   output logic                pair_ok_o,
   output logic [SAMPLE_W-1:0] left_o,
   output logic [SAMPLE_W-1:0] right_o,
   output logic                valid_o
);
   import sad_pkg::*;

   logic [SAMPLE_W-1:0] stage1 [2];
   logic                have_left;

   for (genvar c = 0; c < 2; c++) begin : g_stage1
      logic cap;
      assign cap = (c == int'(CH_LEFT)) ? cap_left_i : cap_right_i;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   stage1[c] <= '0;
         else if (cap) stage1[c] <= word_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         have_left <= 1'b0;
         pair_ok_o <= 1'b0;
      end else begin
         if (cap_left_i) have_left <= 1'b1;
         if (cap_right_i && have_left) pair_ok_o <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_o  <= '0;
         right_o <= '0;
         valid_o <= 1'b0;
      end else begin
         valid_o <= frame_start_i && pair_ok_o;
         if (frame_start_i && pair_ok_o) begin
            left_o  <= stage1[CH_LEFT];
            right_o <= stage1[CH_RIGHT];
         end
      end
   end

   assign s1_left_o  = stage1[CH_LEFT];
   assign s1_right_o = stage1[CH_RIGHT];
endmodule

// File: rtl/serial_audio_deser.sv
module serial_audio_deser #(
   parameter int SAMPLE_W     = sad_pkg::SAD_SAMPLE_W,
   parameter int SYNC_STAGES  = 2,
   parameter bit LEFT_ON_FALL = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sdata_i,
   input  logic                bclk_i,
   input  logic                wclk_i,
   input  logic                frame_start_i,
   output logic [SAMPLE_W-1:0] left_o,
   output logic [SAMPLE_W-1:0] right_o,
   output logic                valid_o
);
   import sad_pkg::*;

   localparam int LINES_W = $bits(sad_lines_t);

   initial begin
      if (SAMPLE_W < 2) $error("serial_audio_deser: SAMPLE_W too small");
      if (SYNC_STAGES < SAD_SYNC_MIN) $error("serial_audio_deser: SYNC_STAGES too small");
   end

   sad_lines_t raw_lines, cur_lines, old_lines;
   logic [LINES_W-1:0] cur_vec, old_vec;

   assign raw_lines = '{sdata: sdata_i, bclk: bclk_i, wclk: wclk_i};

   sad_sync #(.W(LINES_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .async_i(raw_lines),
      .sync_o (cur_vec),
      .prev_o (old_vec)
   );

   assign cur_lines = cur_vec;
   assign old_lines = old_vec;

   logic bit_rise, word_rise, word_fall, cap_left, cap_right;
   assign bit_rise  =  cur_lines.bclk && !old_lines.bclk;
   assign word_rise =  cur_lines.wclk && !old_lines.wclk;
   assign word_fall = !cur_lines.wclk &&  old_lines.wclk;

   if (LEFT_ON_FALL) begin : g_left_fall
      assign cap_left  = word_fall;
      assign cap_right = word_rise;
   end else begin : g_left_rise
      assign cap_left  = word_rise;
      assign cap_right = word_fall;
   end

   logic [SAMPLE_W-1:0] sipo_word;

   sad_sipo #(.SAMPLE_W(SAMPLE_W)) u_sipo (
      .clk    (clk),
      .rst_n  (rst_n),
      .shift_i(bit_rise),
      .bit_i  (cur_lines.sdata),
      .word_o (sipo_word)
   );

   logic [SAMPLE_W-1:0] s1_left, s1_right;
   logic                pair_ok;

   sad_chan_regs #(.SAMPLE_W(SAMPLE_W)) u_chan (
      .clk          (clk),
      .rst_n        (rst_n),
      .cap_left_i   (cap_left),
      .cap_right_i  (cap_right),
      .word_i       (sipo_word),
      .frame_start_i(frame_start_i),
      .s1_left_o    (s1_left),
      .s1_right_o   (s1_right),
      .pair_ok_o    (pair_ok),
      .left_o       (left_o),
      .right_o      (right_o),
      .valid_o      (valid_o)
   );
endmodule

// File: rtl/sad_checker.sv
module sad_checker #(
   parameter int SAMPLE_W = 16
) (
   input logic                clk,
   input logic                rst_n,
   input logic                frame_start_i,
   input logic                valid_o,
   input logic [SAMPLE_W-1:0] left_o,
   input logic [SAMPLE_W-1:0] right_o,
   input logic                pair_ok,
   input logic [SAMPLE_W-1:0] s1_left,
   input logic                cap_left
);
   AST_RESET_CLEAR: assert property (@(posedge clk)
      !rst_n |=> (!valid_o && left_o == '0 && right_o == '0)); // R1

   AST_LEFT_ON_WORD_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(s1_left) |-> $past(cap_left)); // R4

   AST_VALID_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> $past(frame_start_i)); // R5

   AST_VALID_NEEDS_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> pair_ok); // R6

   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(frame_start_i) |-> ($stable(left_o) && $stable(right_o))); // R7
endmodule

bind serial_audio_deser sad_checker #(.SAMPLE_W(SAMPLE_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .frame_start_i(frame_start_i),
   .valid_o      (valid_o),
   .left_o       (left_o),
   .right_o      (right_o),
   .pair_ok      (pair_ok),
   .s1_left      (s1_left),
   .cap_left     (cap_left)
);

// File: tb/serial_audio_deser_test.sv
module serial_audio_deser_test;
   localparam int CLK_PERIOD = 10;
   localparam int HALF_BIT   = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sdata_i = 1'b0;
   logic        bclk_i = 1'b0;
   logic        wclk_i = 1'b1;
   logic        frame_start_i = 1'b0;
   logic [15:0] left_o, right_o;
   logic        valid_o;

   int n_vec = 0;
   int n_bad = 0;
   logic [15:0] exp_l = 16'h0, exp_r = 16'h0;

   serial_audio_deser uut (
      .clk(clk), .rst_n(rst_n), .sdata_i(sdata_i), .bclk_i(bclk_i),
      .wclk_i(wclk_i), .frame_start_i(frame_start_i),
      .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [15:0] tail16(input logic [31:0] stream);
      return stream[15:0];
   endfunction

   function automatic int pick_len(input int sel);
      case (sel % 5)
         0: return 16;
         1: return 17;
         2: return 20;
         3: return 24;
         default: return 32;
      endcase
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic send_half(input logic [31:0] stream, input int nbits, input logic wlevel);
      for (int i = nbits - 1; i >= 0; i--) begin
         @(negedge clk) sdata_i = stream[i];
         repeat (HALF_BIT) @(negedge clk);
         bclk_i = 1'b1;
         repeat (HALF_BIT) @(negedge clk);
         bclk_i = 1'b0;
         sdata_i = ~stream[i];
      end
      repeat (2) @(negedge clk);
      wclk_i = wlevel;
      repeat (6) @(negedge clk);
   endtask

   task automatic strobe_and_check(input logic exp_valid, input string tag);
      @(negedge clk) frame_start_i = 1'b1;
      @(negedge clk) frame_start_i = 1'b0;
      check({tag, " valid"}, {31'b0, valid_o}, {31'b0, exp_valid});
      check({tag, " left"}, {16'b0, left_o}, {16'b0, exp_l});
      check({tag, " right"}, {16'b0, right_o}, {16'b0, exp_r});
      @(negedge clk);
      check("R5 valid single cycle", {31'b0, valid_o}, 32'b0);
   endtask

   task automatic send_pair(input logic [31:0] ls, input logic [31:0] rs, input int n);
      send_half(ls, n, 1'b0);
      send_half(rs, n, 1'b1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_vec++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] ls, rs;
      void'($urandom(32'd1357));
      repeat (4) @(negedge clk);
      check("R1 valid in reset", {31'b0, valid_o}, 32'b0);
      check("R1 left in reset", {16'b0, left_o}, 32'b0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check("R1 right after reset", {16'b0, right_o}, 32'b0);

      // R6: left only, then strobe -> nothing
      send_half(32'h0000_1234, 16, 1'b0);
      strobe_and_check(1'b0, "R6 no pair yet");
      // complete the pair: R4 left on fall, right on rise
      send_half(32'h0000_ABCD, 16, 1'b1);
      exp_l = 16'h1234; exp_r = 16'hABCD;
      strobe_and_check(1'b1, "R4 R8 first pair");

      // directed corners: R2 MSB-first sign handling
      send_pair(32'h0000_8000, 32'h0000_7FFF, 16);
      check("R7 hold before strobe left", {16'b0, left_o}, {16'b0, exp_l});
      exp_l = 16'h8000; exp_r = 16'h7FFF;
      strobe_and_check(1'b1, "R2 extremes");
      // R3: 32-bit slots, upper junk discarded
      send_pair(32'hFFFF_0001, 32'h0000_FFFE, 32);
      exp_l = 16'h0001; exp_r = 16'hFFFE;
      strobe_and_check(1'b1, "R3 long slot");

      for (int k = 0; k < 24; k++) begin
         int n;
         n  = pick_len($urandom);
         ls = $urandom;
         rs = $urandom;
         send_pair(ls, rs, n);
         check("R7 hold left", {16'b0, left_o}, {16'b0, exp_l});
         check("R7 hold right", {16'b0, right_o}, {16'b0, exp_r});
         exp_l = tail16(ls);
         exp_r = tail16(rs);
         strobe_and_check(1'b1, (n > 16) ? "R3 random" : "R2 random");
      end

      // strobe with no new words: same data, fresh pulse
      strobe_and_check(1'b1, "R8 repeat");

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule